// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-line general-purpose I/O port sitting on a simple memory-mapped register bus. Each access is one byte wide. A direction register chooses, pin by pin, whether the port drives the pad or listens to it. Output data is held in a separate register.

Below the direction offset lies a data window. Within that window the access address acts as a per-pin mask. Address bit n+2 selects pin n. Software can therefore set, clear or sample any subset of pins in one access, with no read-modify-write and no race against other code working on the port. Inputs pass through a two-flop synchroniser before they can be read. Read data is registered and appears in the cycle after the read strobe.

Top module: `gpio_mask_port`

## Requirements
- R1: While rst_ni is low and after it is released, pin_oe_o is 0x00, pin_o is 0x00 and rdata_o is 0x00.
- R2: A write at offset 0x400 loads wdata_i into the direction register, seen on pin_oe_o one cycle later (bit n = 1 makes pin n an output). A read at 0x400 returns that register.
- R3: A write at any offset below 0x400 changes pin_o[n] only when address bit n+2 is 1. All other bits of pin_o keep their value.
- R4: A data write to a pin that is currently an input is dropped. When the pin later becomes an output it drives its earlier value, not the dropped one.
- R5: A data read returns 0 in every bit n whose address bit n+2 is 0.
- R6: In a data read, an enabled bit of an output pin returns the value on pin_o.
- R7: In a data read, an enabled bit of an input pin returns pin_i after two flops. A level sampled at clock edge k is not visible to a read strobe sampled at edge k+1. It is visible to a read strobe sampled at edge k+2 or later.
- R8: Reads at offsets above 0x400 return 0x00. Writes there change neither pin_o nor pin_oe_o.
- R9: rdata_o updates on the edge that samples re_i high and holds its value while re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pin_o | output | 8 | Output level per pin |
| pin_oe_o | output | 8 | Output enable per pin (1 = drive) |
| pin_i | input | 8 | Pad input level per pin |

## Verification
The block has only two state registers and a short synchroniser, so a corrupted state shows up at the ports within one cycle.

- A wrong direction bit shows on pin_oe_o the cycle after the write.
- A wrong output bit shows on pin_o at the same time.
- A mask decoded from the wrong address bits disturbs pins that were meant to be left alone, and this is visible directly.
- A synchroniser with the wrong depth moves the first read that sees a new input level by one cycle. The bench therefore reads on both sides of that boundary.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int N_PINS  = 8,
  parameter int DIR_OFS = 'h400
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              acc_o,
  output logic [N_PINS-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] DirAddr = ADDR_W'(DIR_OFS);

  always_comb begin
    if (addr_i < DirAddr)       acc_o = ACC_DATA;
    else if (addr_i == DirAddr) acc_o = ACC_DIR;
    else                        acc_o = ACC_NONE;
  end

  // pin n selected by address bit n+2
  assign mask_o = addr_i[N_PINS+1:2];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N_PINS = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] async_i,
  output logic [N_PINS-1:0] sync_o
);
  logic [N_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_mask_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  acc_e              acc_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o
);
  logic [N_PINS-1:0] dir_q, out_q;
  logic [N_PINS-1:0] out_upd;

  // only masked pins that are outputs take the write
  assign out_upd = (we_i && acc_i == ACC_DATA) ? (mask_i & dir_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          dir_q <= '0;
    else if (we_i && acc_i == ACC_DIR)    dir_q <= wdata_i;

  for (genvar n = 0; n < N_PINS; n++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)         out_q[n] <= 1'b0;
      else if (out_upd[n]) out_q[n] <= wdata_i[n];
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_mask_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  acc_e              acc_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] out_i,
  input  logic [N_PINS-1:0] in_sync_i,
  output logic [N_PINS-1:0] rdata_o
);
  logic [N_PINS-1:0] level, rd_nxt, rdata_q;

  assign level = (dir_i & out_i) | (~dir_i & in_sync_i);

  always_comb begin
    unique case (acc_i)
      ACC_DATA: rd_nxt = level & mask_i;
      ACC_DIR:  rd_nxt = dir_i;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_nxt;

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int N_PINS      = 8,
  parameter int DIR_OFS     = 'h400,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  input  logic [N_PINS-1:0] pin_i
);
  acc_e              acc;
  logic [N_PINS-1:0] mask, dir, out_val, in_sync;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .N_PINS(N_PINS), .DIR_OFS(DIR_OFS)) u_dec (
    .addr_i (addr_i),
    .acc_o  (acc),
    .mask_o (mask)
  );

  gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (in_sync)
  );

  gpio_pin_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .acc_i   (acc),
    .mask_i  (mask),
    .wdata_i (wdata_i),
    .dir_o   (dir),
    .out_o   (out_val)
  );

  gpio_rd_path #(.N_PINS(N_PINS)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .re_i      (re_i),
    .acc_i     (acc),
    .mask_i    (mask),
    .dir_i     (dir),
    .out_i     (out_val),
    .in_sync_i (in_sync),
    .rdata_o   (rdata_o)
  );

  assign pin_o    = out_val;
  assign pin_oe_o = dir;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int ADDR_W  = 12,
  parameter int N_PINS  = 8,
  parameter int DIR_OFS = 'h400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [N_PINS-1:0] rdata_o,
  input logic [N_PINS-1:0] pin_o,
  input logic [N_PINS-1:0] pin_oe_o
);
  localparam logic [ADDR_W-1:0] DirAddr = ADDR_W'(DIR_OFS);

  logic [N_PINS-1:0] amask;
  logic              in_data, in_dir, in_none;
  assign amask   = addr_i[N_PINS+1:2];
  assign in_data = addr_i < DirAddr;
  assign in_dir  = addr_i == DirAddr;
  assign in_none = addr_i > DirAddr;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (pin_o == '0 && pin_oe_o == '0 && rdata_o == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_dir) |=> pin_oe_o == $past(wdata_i));

  // R3
  masked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_data) |=> ((pin_o ^ $past(pin_o)) & ~$past(amask)) == '0);

  // R4
  input_pin_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_data) |=> ((pin_o ^ $past(pin_o)) & ~$past(pin_oe_o)) == '0);

  // R5
  read_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && in_data) |=> (rdata_o & ~$past(amask)) == '0);

  // R6
  read_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && in_data) |=>
      ((rdata_o ^ $past(pin_o)) & $past(amask) & $past(pin_oe_o)) == '0);

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && in_none) |=> rdata_o == '0);

  // R8
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_none) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .ADDR_W(ADDR_W), .N_PINS(N_PINS), .DIR_OFS(DIR_OFS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  localparam int AW = 12;
  localparam int NP = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NP-1:0] wdata_i = '0;
  logic          we_i = 1'b0;
  logic          re_i = 1'b0;
  logic [NP-1:0] rdata_o, pin_o, pin_oe_o;
  logic [NP-1:0] pin_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  logic [NP-1:0] m_dir = '0;
  logic [NP-1:0] m_out = '0;

  typedef struct {
    logic [NP-1:0] exp;
    string         tag;
  } item_t;
  item_t exp_q[$];
  logic  re_d = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_mask_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .pin_i(pin_i)
  );

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_read(logic [AW-1:0] a);
    logic [NP-1:0] lvl;
    lvl = (m_dir & m_out) | (~m_dir & pin_i);
    if (a < 12'h400)       return lvl & a[NP+1:2];
    else if (a == 12'h400) return m_dir;
    else                   return '0;
  endfunction

  // driver tasks: called at a negedge, return at the next negedge
  task automatic wr(logic [AW-1:0] a, logic [NP-1:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == 12'h400) m_dir = d;
    else if (a < 12'h400) m_out = (m_out & ~(a[NP+1:2] & m_dir)) | (d & a[NP+1:2] & m_dir);
  endtask

  task automatic rd(logic [AW-1:0] a, logic [NP-1:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    addr_i = a; re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  // monitor: compare read data one cycle after the strobe was sampled
  always @(posedge clk_i) re_d <= re_i;
  always @(negedge clk_i) begin
    if (re_d) begin
      if (exp_q.size() == 0) check("R9 unexpected read", rdata_o, rdata_o);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, rdata_o, it.exp);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    idle(3);
    // R1 during reset
    check("R1 oe in reset", pin_oe_o, 8'h00);
    check("R1 out in reset", pin_o, 8'h00);
    check("R1 rdata in reset", rdata_o, 8'h00);
    rst_ni = 1'b1;
    idle(2);
    check("R1 oe after reset", pin_oe_o, 8'h00);
    check("R1 out after reset", pin_o, 8'h00);

    // R4: writes to input pins are dropped
    wr(12'h3FC, 8'hFF);
    check("R4 write to inputs", pin_o, 8'h00);
    wr(12'h400, 8'h0F);
    check("R2 oe after dir write", pin_oe_o, 8'h0F);
    check("R4 old value after turn to output", pin_o, 8'h00);
    wr(12'h3FC, 8'hFF);
    check("R4 rewrite after output", pin_o, 8'h0F);

    // R3: address-selected pins only
    wr(12'h020, 8'h00);
    check("R3 single pin 3 clear", pin_o, 8'h07);
    wr(12'h014, 8'h00);
    check("R3 pins 0,2 clear", pin_o, 8'h02);
    wr(12'h004, 8'hFF);
    check("R3 pin 0 set", pin_o, 8'h03);
    wr(12'h004, 8'h00);
    check("R3 pin 0 clear", pin_o, 8'h02);

    // R2 read back
    rd(12'h400, 8'h0F, "R2 dir read");

    // R5 R6: reads with masks
    pin_i = 8'hA5;
    idle(4);
    rd(12'h3FC, exp_read(12'h3FC), "R6 full mask read");
    rd(12'h3C0, exp_read(12'h3C0), "R5 upper mask read");
    rd(12'h00C, exp_read(12'h00C), "R5 R6 lower mask read");
    rd(12'h000, 8'h00, "R5 empty mask read");

    // R9: hold while idle
    idle(3);
    check("R9 rdata holds", rdata_o, 8'h00);
    rd(12'h3FC, exp_read(12'h3FC), "R9 fresh read");
    idle(2);
    check("R9 rdata holds after read", rdata_o, 8'hA2);

    // R8: unmapped
    wr(12'h404, 8'hFF);
    check("R8 unmapped write oe", pin_oe_o, 8'h0F);
    check("R8 unmapped write out", pin_o, 8'h02);
    wr(12'hC00, 8'h00);
    check("R8 high unmapped write oe", pin_oe_o, 8'h0F);
    rd(12'h404, 8'h00, "R8 unmapped read");
    rd(12'hFFC, 8'h00, "R8 top unmapped read");

    // R7: synchroniser latency on input pin 7
    pin_i = 8'h25;
    @(negedge clk_i);
    rd(12'h200, 8'h80, "R7 read at k+1 sees old");
    rd(12'h200, 8'h00, "R7 read at k+2 sees new");

    // R6 after outputs change, inputs flipped to outputs
    wr(12'h400, 8'hF0);
    wr(12'h3FC, 8'h5A);
    check("R4 R3 new outputs", pin_o, 8'h52);
    rd(12'h3FC, exp_read(12'h3FC), "R6 mixed read");

    idle(3);
    if (exp_q.size() != 0) check("R9 pending reads", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule